// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block turns a simple one-transfer request interface into the command pin patterns of a four-bank synchronous DRAM. After reset it brings the device up by itself: a precharge of every bank, two auto refresh commands, then a load of the mode register. Only then does it offer `req_ready`. Each accepted request opens the row, issues a single read or write with auto precharge once the row-to-column delay has passed, and then waits long enough for the bank to close and recover. It issues an auto refresh at a fixed interval, and a due refresh wins over any pending request. The data path is not part of this block.

All spacings are parameters counted in clock cycles. The defaults suit a 7.5 ns clock: row-to-column 2, precharge 2, row active 6, row cycle 8, bank-to-bank activate 2, mode-load 2, and a refresh interval of 1040 cycles. Only one row is open at any time. The next activate therefore waits `ACT_GAP` cycles after the last one. `ACT_GAP` is the largest of the row cycle time, the row active time plus the precharge time, and the bank-to-bank activate delay.

The controller is one state machine:
- **Start-up path.** `ST_POWERUP` (one cycle with CKE low) → `ST_INIT_PALL` → `ST_WAIT` → `ST_INIT_REF` → `ST_WAIT` → `ST_INIT_REF` → `ST_WAIT` → `ST_MRS` → `ST_WAIT` → `ST_IDLE`.
- **From `ST_IDLE`.** The machine goes to `ST_REF` when a refresh is due. Otherwise it goes to `ST_ACT` when a request is accepted.
- **Access path.** `ST_ACT` → `ST_WAIT` → `ST_RW` → `ST_WAIT` → `ST_IDLE`.
- **Refresh path.** `ST_REF` → `ST_WAIT` → `ST_IDLE`.

`ST_WAIT` is shared by every path. A single countdown timer holds it, and a stored resume state says where to go next.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is 0, `req_ready` is 0 and the command pins carry no-operation.
- R2: The command pins {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} use these patterns: no-operation 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode load 0000.
- R3: Start-up runs in this order:
  - a precharge with `sd_addr[10]`=1 (all banks) and `sd_cke`=1;
  - an auto refresh `T_RP` cycles later;
  - a second auto refresh `T_RC` cycles after the first;
  - a mode load `T_RC` cycles after the second, with `sd_ba`=0 and `sd_addr` = CAS_LAT<<4 (that is, burst length 1, sequential, CAS latency in bits 6:4, all other bits 0);
  - `req_ready` rises first `T_RSC` cycles after the mode load.
- R4: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. The activate appears in the next cycle, with `sd_ba`=bank and `sd_addr`=row.
- R5: The read (`req_write`=0) or write (`req_write`=1) appears exactly `T_RCD` cycles after its activate. It carries `sd_ba`=bank, `sd_addr[8:0]`=column and `sd_addr[10]`=1 (auto precharge), with all other address bits 0. Only no-operation appears between the activate and the read or write.
- R6: Two activates are never closer than `ACT_GAP` cycles. After an activate, `req_ready` stays 0 and returns exactly `ACT_GAP` cycles later unless a refresh is due.
- R7: A refresh becomes due every `REF_INTERVAL` cycles.
  - A due refresh is issued before any pending request, and only from idle: at least `ACT_GAP`+1 cycles after the last activate, and no activate follows it within `T_RC` cycles.
  - Consecutive refreshes are at most `REF_INTERVAL`+`ACT_GAP`+2 cycles apart, and exactly `REF_INTERVAL` apart when no access delays them.
- R8: Every cycle that carries no other command is a no-operation, with `sd_cs_n` always 0. After start-up, no precharge command and no burst stop is ever issued, and exactly one precharge and one mode load occur in all.
- R9: A request held on `req_valid` while `req_ready` is 0 (during start-up or a refresh) has no effect until it is accepted. No activate appears before `req_ready` has first risen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ROW_W | Multiplexed row/column/mode address |
| sd_ba | output | BANK_W | Bank select |

## Verification
Accesses sweep every bank and both directions. Rows and columns run from all-zeros to all-ones, plus scattered values, so a mixed-up address, bank or direction field shows up in the decoded activate and read/write patterns. Requests are sent both back-to-back, with `req_valid` held, and with idle gaps of varying length. The back-to-back case shows whether `req_ready` returns exactly at the activate spacing. The gaps shift the refresh ticks against the accesses, so some refreshes are delayed behind an access and others land while the block is idle. Comparing those two cases tells the deadline bound apart from the exact interval. A request held during start-up shows that a request the block is not ready for has no effect.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MRS = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_ACT = 4'b0011,
        CMD_WR  = 4'b0100,
        CMD_RD  = 4'b0101,
        CMD_BST = 4'b0110,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_INIT_PALL,
        ST_INIT_REF,
        ST_MRS,
        ST_IDLE,
        ST_ACT,
        ST_RW,
        ST_REF,
        ST_WAIT
    } seq_state_e;

endpackage

// File: rtl/sdseq_gap_timer.sv
module sdseq_gap_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R6: a running countdown loses exactly one per cycle
    assert_timer_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/sdseq_refresh_tick.sv
module sdseq_refresh_tick #(
    parameter int INTERVAL = 1040
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == CW'(INTERVAL - 1));

    // R7: the refresh tick is a single-cycle pulse
    assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdseq_pkg::*;
#(
    parameter int ROW_W        = 13,
    parameter int COL_W        = 9,
    parameter int BANK_W       = 2,
    parameter int T_RCD        = 2,
    parameter int T_RP         = 2,
    parameter int T_RAS        = 6,
    parameter int T_RC         = 8,
    parameter int T_RRD        = 2,
    parameter int T_RSC        = 2,
    parameter int REF_INTERVAL = 1040,
    parameter int CAS_LAT      = 3,
    parameter int INIT_REFS    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [BANK_W-1:0] sd_ba
);
    localparam int AP_BIT    = 10;
    localparam int CLOSE_GAP = T_RAS + T_RP;
    localparam int GAP_A     = (T_RC > CLOSE_GAP) ? T_RC : CLOSE_GAP;
    localparam int ACT_GAP   = (GAP_A > T_RRD) ? GAP_A : T_RRD;
    localparam int TMR_W     = $clog2(ACT_GAP + T_RC + T_RP + T_RSC + 1);
    localparam int RC_W      = $clog2(INIT_REFS + 1);
    localparam logic [ROW_W-1:0] MODE_WORD = ROW_W'(CAS_LAT << 4);

    seq_state_e state, nxt_state, resume, nxt_resume;
    sd_cmd_e    cmd;

    logic              tmr_load, tmr_zero, tick, ref_due, accept, cke_q;
    logic [TMR_W-1:0]  tmr_val;
    logic [RC_W-1:0]   refs_left;
    logic              we_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;

    sdseq_gap_timer #(.W(TMR_W)) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    sdseq_refresh_tick #(.INTERVAL(REF_INTERVAL)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign req_ready = (state == ST_IDLE) && !ref_due;
    assign accept    = req_ready && req_valid;

    // next state, resume target and timer load
    always_comb begin
        nxt_state  = state;
        nxt_resume = resume;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (state)
            ST_POWERUP:   nxt_state = ST_INIT_PALL;
            ST_INIT_PALL: begin
                tmr_load = 1'b1; tmr_val = TMR_W'(T_RP - 2);
                nxt_state = ST_WAIT; nxt_resume = ST_INIT_REF;
            end
            ST_INIT_REF: begin
                tmr_load = 1'b1; tmr_val = TMR_W'(T_RC - 2);
                nxt_state = ST_WAIT;
                nxt_resume = (refs_left == RC_W'(1)) ? ST_MRS : ST_INIT_REF;
            end
            ST_MRS: begin
                tmr_load = 1'b1; tmr_val = TMR_W'(T_RSC - 2);
                nxt_state = ST_WAIT; nxt_resume = ST_IDLE;
            end
            ST_IDLE: begin
                if (ref_due)
                    nxt_state = ST_REF;
                else if (req_valid)
                    nxt_state = ST_ACT;
            end
            ST_ACT: begin
                tmr_load = 1'b1; tmr_val = TMR_W'(T_RCD - 2);
                nxt_state = ST_WAIT; nxt_resume = ST_RW;
            end
            ST_RW: begin
                tmr_load = 1'b1; tmr_val = TMR_W'(ACT_GAP - T_RCD - 2);
                nxt_state = ST_WAIT; nxt_resume = ST_IDLE;
            end
            ST_REF: begin
                tmr_load = 1'b1; tmr_val = TMR_W'(T_RC - 2);
                nxt_state = ST_WAIT; nxt_resume = ST_IDLE;
            end
            ST_WAIT: begin
                if (tmr_zero)
                    nxt_state = resume;
            end
            default: nxt_state = ST_POWERUP;
        endcase
    end

    // state register and request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_POWERUP;
            resume    <= ST_IDLE;
            refs_left <= RC_W'(INIT_REFS);
            ref_due   <= 1'b0;
            cke_q     <= 1'b0;
            we_q      <= 1'b0;
            bank_q    <= '0;
            row_q     <= '0;
            col_q     <= '0;
        end else begin
            state  <= nxt_state;
            resume <= nxt_resume;
            cke_q  <= 1'b1;
            if (state == ST_INIT_REF)
                refs_left <= refs_left - 1'b1;
            if (tick)
                ref_due <= 1'b1;
            else if (state == ST_REF)
                ref_due <= 1'b0;
            if (accept) begin
                we_q   <= req_write;
                bank_q <= req_bank;
                row_q  <= req_row;
                col_q  <= req_col;
            end
        end
    end

    // command pins from state
    always_comb begin
        cmd     = CMD_NOP;
        sd_addr = '0;
        sd_ba   = '0;
        unique case (state)
            ST_INIT_PALL: begin
                cmd = CMD_PRE;
                sd_addr[AP_BIT] = 1'b1;
            end
            ST_INIT_REF, ST_REF: cmd = CMD_REF;
            ST_MRS: begin
                cmd = CMD_MRS;
                sd_addr = MODE_WORD;
            end
            ST_ACT: begin
                cmd = CMD_ACT;
                sd_addr = row_q;
                sd_ba = bank_q;
            end
            ST_RW: begin
                cmd = we_q ? CMD_WR : CMD_RD;
                sd_addr[COL_W-1:0] = col_q;
                sd_addr[AP_BIT] = 1'b1;
                sd_ba = bank_q;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign sd_cke = cke_q;

    // R4: an accepted request produces its activate on the next cycle
    assert_act_follows_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011
                    && sd_ba == $past(req_bank) && sd_addr == $past(req_row)));

    // R5: activate is followed by no-operation (row-to-column delay of at least 2)
    assert_act_then_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0011)
        |=> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));

    // R5: column commands always request auto precharge
    assert_rw_autopre_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && sd_ras_n && !sd_cas_n) |-> sd_addr[AP_BIT]);

    // R7: a due refresh in idle wins over any request
    assert_refresh_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_due && state == ST_IDLE) |=> (state == ST_REF));

    // R8: offering ready coincides with a no-operation on the pins
    assert_ready_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111));

endmodule

// File: tb/sim_sdram_cmd_seq.sv
module sim_sdram_cmd_seq;
    localparam int TRCD = 2, TRP = 2, TRAS = 6, TRC = 8, TRRD = 2, TRSC = 2;
    localparam int INT  = 100, CL = 3;
    localparam int A2A  = (TRC > TRAS + TRP) ? TRC : ((TRAS + TRP > TRRD) ? TRAS + TRP : TRRD);

    localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                           P_WR = 4'b0100, P_PRE = 4'b0010, P_REF = 4'b0001,
                           P_MRS = 4'b0000;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [1:0]  req_bank = '0;
    logic [12:0] req_row = '0;
    logic [8:0]  req_col = '0;
    logic        req_ready, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [12:0] sd_addr;
    logic [1:0]  sd_ba;
    logic [3:0]  pins;

    int nvec = 0, nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sdram_cmd_seq #(.REF_INTERVAL(INT), .CAS_LAT(CL)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_addr(sd_addr), .sd_ba(sd_ba)
    );

    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    endtask

    // pin monitor: spacing and legality rules
    int  cyc = 0, last_act = -1, last_ref = -1, n_pre = 0, n_mrs = 0;
    int  pall_c = -1, iref1 = -1, iref2 = -1, mrs_c = -1, rdy_c = -1;
    bit  prev_clean = 0, act_since_ref = 0;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            cyc++;
            if (req_ready && rdy_c < 0) rdy_c = cyc;
            chk(!sd_cs_n && pins != 4'b0110, "R8", "cs low and no burst stop", pins, P_NOP);
            case (pins)
                P_PRE: begin
                    n_pre++;
                    chk(n_pre == 1 && sd_addr[10], "R8", "single all-bank precharge", n_pre, 1);
                    chk(sd_cke == 1'b1, "R3", "cke high at precharge", sd_cke, 1);
                    pall_c = cyc;
                end
                P_MRS: begin
                    n_mrs++;
                    chk(n_mrs == 1, "R8", "single mode load", n_mrs, 1);
                    chk(sd_addr == 13'(CL << 4) && sd_ba == 0, "R3", "mode word",
                        sd_addr, CL << 4);
                    mrs_c = cyc;
                end
                P_ACT: begin
                    chk(rdy_c >= 0, "R9", "no activate before ready", rdy_c, 1);
                    if (last_act >= 0)
                        chk(cyc - last_act >= A2A, "R6", "activate spacing", cyc - last_act, A2A);
                    if (last_ref >= 0)
                        chk(cyc - last_ref >= TRC, "R7", "refresh to activate", cyc - last_ref, TRC);
                    last_act = cyc;
                    act_since_ref = 1;
                end
                P_REF: begin
                    if (mrs_c < 0) begin
                        if (iref1 < 0) iref1 = cyc; else iref2 = cyc;
                    end else begin
                        bit clean;
                        clean = (last_act < 0) || (cyc - last_act > A2A + 1);
                        if (last_act >= 0)
                            chk(cyc - last_act > A2A, "R7", "refresh only from idle",
                                cyc - last_act, A2A + 1);
                        if (last_ref >= iref2 && last_ref > 0 && last_ref != iref2) begin
                            if (prev_clean && clean && !act_since_ref)
                                chk(cyc - last_ref == INT, "R7", "idle refresh interval",
                                    cyc - last_ref, INT);
                            else
                                chk(cyc - last_ref <= INT + A2A + 2, "R7", "refresh deadline",
                                    cyc - last_ref, INT + A2A + 2);
                        end
                        prev_clean = clean;
                        act_since_ref = 0;
                    end
                    last_ref = cyc;
                end
                P_NOP, P_RD, P_WR: ;
                default: chk(0, "R2", "illegal command pattern", pins, P_NOP);
            endcase
        end
    end

    // one access: returns once the row is ready again or a refresh follows
    task automatic do_access(input logic [1:0] b, input logic [12:0] r,
                             input logic [8:0] c, input bit w);
        bit rdy;
        req_valid = 1'b1; req_bank = b; req_row = r; req_col = c; req_write = w;
        forever begin
            rdy = req_ready;
            @(posedge clk);
            @(negedge clk);
            if (rdy) break;
        end
        req_valid = 1'b0;
        chk(pins == P_ACT, "R4", "activate after accept", pins, P_ACT);
        chk(sd_ba == b, "R4", "activate bank", sd_ba, b);
        chk(sd_addr == r, "R4", "activate row", sd_addr, r);
        for (int i = 1; i < TRCD; i++) begin
            @(negedge clk);
            chk(pins == P_NOP, "R5", "nop before column command", pins, P_NOP);
        end
        @(negedge clk);
        chk(pins == (w ? P_WR : P_RD), "R5", "read/write pattern", pins, w ? P_WR : P_RD);
        chk(sd_addr == {2'b00, 1'b1, 1'b0, c}, "R5", "column address with auto precharge",
            sd_addr, {2'b00, 1'b1, 1'b0, c});
        chk(sd_ba == b, "R5", "column bank", sd_ba, b);
        for (int i = 1; i < A2A - TRCD; i++) begin
            @(negedge clk);
            chk(!req_ready, "R6", "ready low during recovery", req_ready, 0);
        end
        @(negedge clk);
        if (!req_ready) begin
            @(negedge clk);
            chk(pins == P_REF, "R7", "refresh wins when ready withheld", pins, P_REF);
        end else begin
            chk(1, "R6", "ready back after activate gap", 1, 1);
        end
    endtask

    initial begin
        repeat (4) begin
            @(negedge clk);
            chk(sd_cke == 0, "R1", "cke in reset", sd_cke, 0);
            chk(!req_ready, "R1", "ready in reset", req_ready, 0);
            chk(pins == P_NOP, "R1", "nop in reset", pins, P_NOP);
        end
        rst_n = 1'b1;
        // R9: request held from the start of initialisation
        do_access(2'd3, 13'h1ABC, 9'h1F5, 1'b1);
        chk(iref1 - pall_c == TRP, "R3", "precharge to refresh", iref1 - pall_c, TRP);
        chk(iref2 - iref1 == TRC, "R3", "refresh to refresh", iref2 - iref1, TRC);
        chk(mrs_c - iref2 == TRC, "R3", "refresh to mode load", mrs_c - iref2, TRC);
        chk(rdy_c - mrs_c == TRSC, "R3", "mode load to ready", rdy_c - mrs_c, TRSC);
        for (int b = 0; b < 4; b++)
            for (int w = 0; w < 2; w++)
                for (int k = 0; k < 4; k++) begin
                    logic [12:0] r;
                    logic [8:0]  c;
                    r = (k == 3) ? 13'h1FFF : 13'((b * 4099 + w * 1111 + k * 797) * (k != 0));
                    c = (k == 3) ? 9'h1FF : 9'((b * 37 + w * 101 + k * 59) * (k != 0));
                    repeat ((b + k) % 4) @(negedge clk);
                    do_access(2'(b), r, c, w[0]);
                end
        req_valid = 1'b0;
        repeat (5 * INT) @(negedge clk);
        chk(last_ref > 0 && cyc - last_ref <= INT, "R7", "refresh continues while idle",
            cyc - last_ref, INT);
        finish_up();
    end

    initial begin
        repeat (20000) @(posedge clk);
        nvec++;
        nerr++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        finish_up();
    end

endmodule